// File: doc/BRIEF.md
# Three-Level Interrupt Status Tree

This block gathers a wide vector of interrupt lines, up to 256 by default, and reports them to a host through a tree of small status registers. Lines are grouped eight to a block, and blocks eight to a master. A root register flags which masters have pending work, each master register flags which of its blocks do, and the host then looks at one block at a time through a selection window. One output, `irq_out`, tells the host that something in the tree is pending.

Each line has its own trigger setting: edge or level mode, and separate enables for the rising/high and falling/low conditions. The host reaches both the per-line setting and the per-block status indirectly. It first writes a block number into a select register. It then reads the latched or the live status of that block, or writes one packed configuration byte that names a line inside the block. The same byte can also clear that line's latched bit. Lines pass through a multi-flop synchronizer before detection, so they may come from any clock domain.

The host port is a plain 10-bit address, 8-bit data register port. A write takes effect on the clock edge where `bus_wen` is high. Read data is combinational from the address and has no side effects.

Top module: `irq_tree_aggr`

## Requirements
- R1: The register window starts at `BASE_ADDR` (default 0x1BB). It has these offsets: 0 root, 1 to 4 master status for masters 0 to 3, 5 block select (read/write), 6 latched status of the selected block, 7 configuration (write-only, reads 0), and 8 live status of the selected block. Any address outside the window reads 0, and writes to it are ignored.
- R2: After reset every line is in edge mode with both trigger enables masked. All latched status is 0, the block select is 0 and `irq_out` is low.
- R3: A write to offset 7 acts only when data bit 7 is 1. In that byte, bits 6:4 give the line within the selected block, bit 0 = 1 selects level mode, bit 1 = 1 masks the falling edge or low level, and bit 2 = 1 masks the rising edge or high level.
- R4: In edge mode, a rising edge latches the line when bit 2 was written 0, and a falling edge latches it when bit 1 was written 0. With both masks set, no edge latches.
- R5: In level mode, a high input latches the line when bit 2 is 0, and a low input latches it when bit 1 is 0.
- R6: A committed configuration byte with bit 3 = 1 clears that line's latched bit. A level-mode line whose condition still holds latches again on the next cycle. An edge-mode line stays clear until a new edge arrives.
- R7: A latched bit stays set after its input returns to the inactive state, until it is cleared.
- R8: Line bit i of block b is interrupt number b*8+i. Offset 6 returns the eight latched bits of the selected block, with bit i for line i.
- R9: Bit i of master m's register is 1 when block m*8+i holds a latched line whose two masks are not both set. A latched line with both masks set stays visible at offset 6 but is not reported upward.
- R10: Root bit k+1 is the OR of master k's register. Root bit 0 always reads 0. `irq_out` is the OR of the root bits.
- R11: Offset 8 returns the synchronized present levels of the selected block's lines. A change on an input shows there after `SYNC_STAGES` clock edges, and a latch caused by that change appears one edge later.
- R12: When the block select holds a value at or above the number of blocks, offsets 6 and 8 read 0 and configuration writes change no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | Raw interrupt lines, any clock domain |
| bus_addr | input | 10 | Register address |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq_out | output | 1 | Aggregated pending interrupt |

## Verification
The assertions check the invariants that hold on every cycle at the register port:
- root bit 0 reads zero, and `irq_out` agrees with any read of the root;
- addresses outside the window read zero;
- the block select captures each write to it;
- an out-of-range select hides offsets 6 and 8.

The trigger behaviour needs the bench's scenarios and its bench-side reference model. That covers edge versus level detection, the separate rising and falling masks, sticky latching, the re-latch of a level line after a clear, the refusal of uncommitted bytes, and the way masking removes a line from the master and root bits while offset 6 still shows it.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
   // Fixed geometry of the register layout
   localparam int LINES_PER_BLK  = 8;
   localparam int BLKS_PER_MSTR  = 8;
   localparam int WIN_MASTERS    = 4;

   // Offsets inside the window
   localparam logic [3:0] OFS_ROOT  = 4'd0;
   localparam logic [3:0] OFS_SEL   = 4'd5;
   localparam logic [3:0] OFS_LATCH = 4'd6;
   localparam logic [3:0] OFS_CFG   = 4'd7;
   localparam logic [3:0] OFS_LIVE  = 4'd8;
   localparam logic [9:0] WIN_LAST  = 10'd8;

   // Fields of the packed configuration byte
   localparam int CFG_LEVEL   = 0;
   localparam int CFG_MASK_LO = 1;
   localparam int CFG_MASK_HI = 2;
   localparam int CFG_CLR     = 3;
   localparam int CFG_SEL_LSB = 4;
   localparam int CFG_COMMIT  = 7;

   typedef struct packed {
      logic level;
      logic mask_lo;
      logic mask_hi;
   } line_cfg_t;

   localparam line_cfg_t CFG_RESET = '{level: 1'b0, mask_lo: 1'b1, mask_hi: 1'b1};
endpackage

// File: rtl/irq_tree_sync.sv
module irq_tree_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= '0;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_tree_line.sv
module irq_tree_line
   import irq_tree_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lvl,
   input  logic      cfg_we,
   input  line_cfg_t cfg_d,
   input  logic      clr,
   output logic      lat,
   output logic      armed
);
   line_cfg_t cfg_q;
   logic      prev_q;
   logic      hit;

   always_comb begin
      if (cfg_q.level)
         hit = (lvl && !cfg_q.mask_hi) || (!lvl && !cfg_q.mask_lo);
      else
         hit = (lvl && !prev_q && !cfg_q.mask_hi) || (!lvl && prev_q && !cfg_q.mask_lo);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= CFG_RESET;
         prev_q <= 1'b0;
         lat    <= 1'b0;
      end else begin
         prev_q <= lvl;
         if (cfg_we) cfg_q <= cfg_d;
         if (clr)      lat <= 1'b0;
         else if (hit) lat <= 1'b1;
      end
   end

   assign armed = !(cfg_q.mask_hi && cfg_q.mask_lo);
endmodule

// File: rtl/irq_tree_aggr.sv
module irq_tree_aggr
   import irq_tree_pkg::*;
#(
   parameter int         NUM_LINES   = 256,
   parameter logic [9:0] BASE_ADDR   = 10'h1BB,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic [9:0]           bus_addr,
   input  logic                 bus_wen,
   input  logic [7:0]           bus_wdata,
   output logic [7:0]           bus_rdata,
   output logic                 irq_out
);
   localparam int NUM_BLOCKS  = NUM_LINES / LINES_PER_BLK;
   localparam int NUM_MASTERS = (NUM_BLOCKS + BLKS_PER_MSTR - 1) / BLKS_PER_MSTR;
   localparam int PEND_BITS   = WIN_MASTERS * BLKS_PER_MSTR;
   localparam int SEL_W       = $clog2(NUM_BLOCKS);

   // Elaboration-time parameter checks
   if (NUM_LINES % LINES_PER_BLK != 0) begin : g_chk_mult
      $error("NUM_LINES must be a multiple of 8");
   end
   if (NUM_BLOCKS < 2 || NUM_MASTERS > WIN_MASTERS) begin : g_chk_range
      $error("NUM_LINES must lie between 16 and 256");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (32'(BASE_ADDR) + 8 > 1023) begin : g_chk_base
      $error("register window exceeds address space");
   end

   logic [NUM_LINES-1:0] lvl, lat, armed;
   logic [7:0]           blk_sel;
   logic [9:0]           ofs;
   logic                 in_win, wr_sel, wr_cfg, sel_ok;
   logic [SEL_W-1:0]     sel_idx;
   line_cfg_t            cfg_d;
   logic [7:0]           blk_lat  [NUM_BLOCKS];
   logic [7:0]           blk_live [NUM_BLOCKS];
   logic [PEND_BITS-1:0] blk_pend;
   logic [7:0]           mst_reg  [WIN_MASTERS];
   logic [WIN_MASTERS-1:0] mst_any;
   logic [1:0]           mst_idx;
   logic [7:0]           root;

   irq_tree_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_in), .q(lvl)
   );

   // Address decode
   assign ofs     = bus_addr - BASE_ADDR;
   assign in_win  = (bus_addr >= BASE_ADDR) && (ofs <= WIN_LAST);
   assign wr_sel  = bus_wen && in_win && (ofs[3:0] == OFS_SEL);
   assign wr_cfg  = bus_wen && in_win && (ofs[3:0] == OFS_CFG) && bus_wdata[CFG_COMMIT];
   assign sel_ok  = (32'(blk_sel) < NUM_BLOCKS);
   assign sel_idx = blk_sel[SEL_W-1:0];
   assign cfg_d   = '{level:   bus_wdata[CFG_LEVEL],
                      mask_lo: bus_wdata[CFG_MASK_LO],
                      mask_hi: bus_wdata[CFG_MASK_HI]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      blk_sel <= '0;
      else if (wr_sel) blk_sel <= bus_wdata;
   end

   // Line cells
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      localparam int LBLK = i / LINES_PER_BLK;
      localparam int LBIT = i % LINES_PER_BLK;
      logic hit_we;
      assign hit_we = wr_cfg && sel_ok && (blk_sel == 8'(LBLK)) &&
                      (bus_wdata[CFG_SEL_LSB +: 3] == 3'(LBIT));
      irq_tree_line u_line (
         .clk(clk), .rst_n(rst_n), .lvl(lvl[i]),
         .cfg_we(hit_we), .cfg_d(cfg_d),
         .clr(hit_we && bus_wdata[CFG_CLR]),
         .lat(lat[i]), .armed(armed[i])
      );
   end

   // Block level, padded out to the full master window
   for (genvar b = 0; b < PEND_BITS; b++) begin : g_blk
      if (b < NUM_BLOCKS) begin : g_real
         assign blk_lat[b]  = lat[b*LINES_PER_BLK +: LINES_PER_BLK];
         assign blk_live[b] = lvl[b*LINES_PER_BLK +: LINES_PER_BLK];
         assign blk_pend[b] = |(lat[b*LINES_PER_BLK +: LINES_PER_BLK] &
                                armed[b*LINES_PER_BLK +: LINES_PER_BLK]);
      end else begin : g_pad
         assign blk_pend[b] = 1'b0;
      end
   end

   // Master and root level
   for (genvar m = 0; m < WIN_MASTERS; m++) begin : g_mst
      assign mst_reg[m] = blk_pend[m*BLKS_PER_MSTR +: BLKS_PER_MSTR];
      assign mst_any[m] = |mst_reg[m];
   end

   assign root    = {3'b000, mst_any, 1'b0};
   assign irq_out = |mst_any;
   assign mst_idx = ofs[1:0] - 2'd1;

   // Read mux
   always_comb begin
      bus_rdata = '0;
      if (in_win) begin
         case (ofs[3:0])
            OFS_ROOT:                bus_rdata = root;
            4'd1, 4'd2, 4'd3, 4'd4:  bus_rdata = mst_reg[mst_idx];
            OFS_SEL:                 bus_rdata = blk_sel;
            OFS_LATCH:               bus_rdata = sel_ok ? blk_lat[sel_idx]  : '0;
            OFS_LIVE:                bus_rdata = sel_ok ? blk_live[sel_idx] : '0;
            default:                 bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/irq_tree_aggr_chk.sv
module irq_tree_aggr_chk #(
   parameter logic [9:0] BASE_ADDR  = 10'h1BB,
   parameter int         NUM_BLOCKS = 32
) (
   input logic       clk,
   input logic       rst_n,
   input logic [9:0] bus_addr,
   input logic       bus_wen,
   input logic [7:0] bus_wdata,
   input logic [7:0] bus_rdata,
   input logic       irq_out,
   input logic [7:0] sel_q
);
   a_r10_root_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == BASE_ADDR) |-> !bus_rdata[0]);

   a_r10_irq_matches_root: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == BASE_ADDR) |-> (irq_out == (|bus_rdata[7:1])));

   a_r1_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_addr < BASE_ADDR) || (bus_addr > BASE_ADDR + 10'd8)) |-> (bus_rdata == 8'h00));

   a_r1_select_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && (bus_addr == BASE_ADDR + 10'd5)) |=> (sel_q == $past(bus_wdata)));

   a_r12_bad_select_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (((bus_addr == BASE_ADDR + 10'd6) || (bus_addr == BASE_ADDR + 10'd8)) &&
       (32'(sel_q) >= NUM_BLOCKS)) |-> (bus_rdata == 8'h00));

   a_r2_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !irq_out);
endmodule

bind irq_tree_aggr irq_tree_aggr_chk #(.BASE_ADDR(BASE_ADDR), .NUM_BLOCKS(NUM_BLOCKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out), .sel_q(blk_sel)
);

// File: tb/irq_tree_aggr_tb_top.sv
`timescale 1ns/1ps
module irq_tree_aggr_tb_top;
   localparam int         NL   = 256;
   localparam int         NB   = NL / 8;
   localparam logic [9:0] BASE = 10'h1BB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] irq_in = '0;
   logic [9:0]    bus_addr = '0;
   logic          bus_wen = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic          irq_out;

   int  n_checks = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   // Reference model state
   logic [NL-1:0] m_in = '0;
   bit m_lvl [NL];
   bit m_mlo [NL];
   bit m_mhi [NL];
   bit m_lat [NL];

   always #2 clk = ~clk;

   irq_tree_aggr #(.NUM_LINES(NL), .BASE_ADDR(BASE), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
      .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic void model_settle();
      for (int i = 0; i < NL; i++)
         if (m_lvl[i] && ((m_in[i] && !m_mhi[i]) || (!m_in[i] && !m_mlo[i]))) m_lat[i] = 1'b1;
   endfunction

   function automatic void model_inputs(input logic [NL-1:0] nv);
      for (int i = 0; i < NL; i++)
         if (!m_lvl[i] && ((nv[i] && !m_in[i] && !m_mhi[i]) || (!nv[i] && m_in[i] && !m_mlo[i])))
            m_lat[i] = 1'b1;
      m_in = nv;
      model_settle();
   endfunction

   function automatic void model_cfg(input int blk, input logic [7:0] w);
      int idx;
      if (!w[7] || blk >= NB) return;
      idx = blk * 8 + int'(w[6:4]);
      m_lvl[idx] = w[0];
      m_mlo[idx] = w[1];
      m_mhi[idx] = w[2];
      if (w[3]) m_lat[idx] = 1'b0;
      model_settle();
   endfunction

   function automatic logic [7:0] exp_blk(input int b);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = m_lat[b*8+i];
      return r;
   endfunction

   function automatic logic exp_pend(input int b);
      logic p = 1'b0;
      for (int i = 0; i < 8; i++) p |= m_lat[b*8+i] && !(m_mlo[b*8+i] && m_mhi[b*8+i]);
      return p;
   endfunction

   task automatic bus_write(input logic [9:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic bus_read(input logic [9:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_wen = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic cfg_line(input int blk, input logic [7:0] w);
      bus_write(BASE + 10'd5, 8'(blk));
      bus_write(BASE + 10'd7, w);
      model_cfg(blk, w);
      repeat (3) @(negedge clk);
   endtask

   task automatic set_inputs(input logic [NL-1:0] nv);
      @(negedge clk);
      irq_in = nv;
      model_inputs(nv);
      repeat (4) @(negedge clk);
   endtask

   task automatic read_blk(input int blk, output logic [7:0] d);
      bus_write(BASE + 10'd5, 8'(blk));
      bus_read(BASE + 10'd6, d);
   endtask

   task automatic check_all(input string ctx);
      logic [7:0] d, r;
      logic [3:0] ma;
      for (int b = 0; b < NB; b++) begin
         bus_write(BASE + 10'd5, 8'(b));
         bus_read(BASE + 10'd6, d);
         chk({"R8 latched block ", ctx}, d, exp_blk(b));
         bus_read(BASE + 10'd8, d);
         chk({"R11 live block ", ctx}, d, m_in[b*8 +: 8]);
      end
      ma = '0;
      for (int m = 0; m < 4; m++) begin
         for (int i = 0; i < 8; i++) r[i] = exp_pend(m*8 + i);
         ma[m] = |r;
         bus_read(BASE + 10'(1 + m), d);
         chk({"R9 master ", ctx}, d, r);
      end
      bus_read(BASE, d);
      chk({"R10 root ", ctx}, d, {3'b000, ma, 1'b0});
      chk({"R10 irq_out ", ctx}, irq_out, |ma);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] d;
      logic [NL-1:0] nv;
      int unsigned seed;
      seed = 32'h5EED_1234;
      void'($urandom(seed));
      for (int i = 0; i < NL; i++) begin
         m_lvl[i] = 1'b0; m_mlo[i] = 1'b1; m_mhi[i] = 1'b1; m_lat[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset state
      #1 chk("R2 irq_out after reset", irq_out, 0);
      bus_read(BASE + 10'd5, d);
      chk("R2 select after reset", d, 0);
      check_all("R2 reset");

      // R2 masks set at reset: edges do not latch
      nv = '0; nv[0] = 1'b1; nv[100] = 1'b1;
      set_inputs(nv);
      read_blk(0, d);
      chk("R2 reset masks block edges", d, 0);

      // R1 outside window and config readback
      bus_read(BASE - 10'd1, d);
      chk("R1 below window reads 0", d, 0);
      bus_read(BASE + 10'd9, d);
      chk("R1 above window reads 0", d, 0);
      bus_read(BASE + 10'd7, d);
      chk("R1 config offset reads 0", d, 0);
      bus_write(BASE + 10'd5, 8'h11);
      bus_read(BASE + 10'd5, d);
      chk("R1 select readback", d, 8'h11);

      // R3 uncommitted byte (bit7=0) enabling rising edge on block3 line5
      cfg_line(3, 8'h52);
      nv = m_in; nv[29] = 1'b1;
      set_inputs(nv);
      read_blk(3, d);
      chk("R3 uncommitted write ignored", d, 0);

      // R4 edge rising enabled on block0 line2 (byte 0xA2)
      cfg_line(0, 8'hA2);
      nv = m_in; nv[2] = 1'b1;
      set_inputs(nv);
      read_blk(0, d);
      chk("R4 rising edge latched", d, 8'h04);
      chk("R10 irq_out raised", irq_out, 1);
      bus_read(BASE, d);
      chk("R10 root bit1 for master0", d, 8'h02);

      // R7 sticky after input falls (falling masked)
      nv = m_in; nv[2] = 1'b0;
      set_inputs(nv);
      read_blk(0, d);
      chk("R7 sticky after release", d, 8'h04);

      // R6 clear on edge line stays clear
      cfg_line(0, 8'hAA);
      read_blk(0, d);
      chk("R6 edge clear stays clear", d, 0);

      // R4 falling edge enabled on block0 line2 (byte 0xA4)
      cfg_line(0, 8'hA4);
      nv = m_in; nv[2] = 1'b1;
      set_inputs(nv);
      read_blk(0, d);
      chk("R4 rising ignored when masked", d, 0);
      nv = m_in; nv[2] = 1'b0;
      set_inputs(nv);
      read_blk(0, d);
      chk("R4 falling edge latched", d, 8'h04);

      // R5 level high on block1 line1 (byte 0x93), R6 re-latch
      nv = m_in; nv[9] = 1'b1;
      set_inputs(nv);
      cfg_line(1, 8'h93);
      read_blk(1, d);
      chk("R5 level high latched", d, 8'h02);
      cfg_line(1, 8'h9B);
      read_blk(1, d);
      chk("R6 level re-latches after clear", d, 8'h02);
      nv = m_in; nv[9] = 1'b0;
      set_inputs(nv);
      cfg_line(1, 8'h9B);
      read_blk(1, d);
      chk("R6 level clear after release", d, 0);

      // R5 active low on block5 line0 (byte 0x85), input already low
      cfg_line(5, 8'h85);
      read_blk(5, d);
      chk("R5 level low latched", d, 8'h01);

      // R9 masking both hides from master but not block status
      cfg_line(5, 8'h86);
      read_blk(5, d);
      chk("R9 masked line still latched", d, 8'h01);
      bus_read(BASE + 10'd1, d);
      chk("R9 masked line not in master0", d[5], 0);

      // R12 out-of-range select
      nv = m_in; nv[7] = 1'b1; nv[255] = 1'b1;
      set_inputs(nv);
      bus_write(BASE + 10'd5, 8'(NB + 8));
      bus_read(BASE + 10'd8, d);
      chk("R12 live hidden on bad select", d, 0);
      bus_read(BASE + 10'd6, d);
      chk("R12 latched hidden on bad select", d, 0);
      cfg_line(NB + 8, 8'h81);
      check_all("R12 no line touched");

      // Constrained random mix
      for (int it = 0; it < 40; it++) begin
         int sel;
         logic [7:0] w;
         sel = int'($urandom % 3);
         if (sel == 0) begin
            w = 8'($urandom);
            if (($urandom % 8) != 0) w[7] = 1'b1;
            cfg_line(int'($urandom % NB), w);
         end else if (sel == 1) begin
            nv = m_in;
            for (int k = 0; k < NL/32; k++) nv[k*32 +: 32] ^= $urandom & $urandom & $urandom;
            set_inputs(nv);
         end else begin
            int b, l;
            b = int'($urandom % NB);
            l = int'($urandom % 8);
            w = {1'b1, 3'(l), 1'b1, m_mhi[b*8+l], m_mlo[b*8+l], m_lvl[b*8+l]};
            cfg_line(b, w);
         end
         check_all("random");
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule